// File: doc/BRIEF.md
# Dual-Channel Converter Serial Readout Controller

This block sits on the host side of a serial link to a two-channel, 12-bit sampling converter. From the system clock it generates an active-low chip-select and a serial clock whose period is a parameter. A one-cycle start request opens a frame. The controller then runs enough serial clocks to cover the converter's 19-clock conversion latency and shifts in one result from each of the two data lines. The results appear as two words together with a one-cycle valid pulse.

Two options are taken from input pins when a frame starts. The capture edge can be the rising or the falling serial-clock edge. Rising-edge capture gives the converter's output access time a full half period at the fastest serial rate. In single-line mode the frame is 12 clocks longer and both channel results are read from data line A alone: the line's own channel first, then the other channel. After a frame the chip-select stays high for a minimum number of system clocks before another start is accepted.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is asserted and directly after it, csN and sclk are high and busy and valid are low.
- R2: While csN is high, sclk stays high. During a frame, sclk is low for SCLK_DIV/2 system clocks and then high for SCLK_DIV/2 system clocks.
- R3: csN falls on the cycle after an accepted start, with sclk high. The first sclk falling edge comes exactly SCLK_DIV/2 system clocks after csN falls, so it never coincides with the fall of csN.
- R4: A normal frame has exactly 31 sclk falling edges while csN is low. A single-line frame has exactly 43.
- R5: With captureRise=0 the data lines are sampled at sclk falling edges 20 to 31 (counted from the fall of csN). The first sampled bit is the MSB of the result.
- R6: With captureRise=1 the data lines are sampled at the sclk rising edges that follow falling edges 19 to 30. The first sampled bit is the MSB.
- R7: With singleLine=1, line A alone is sampled over 24 bits. The first 12 bits form resultA and the next 12 form resultB. Line B has no effect on either result.
- R8: valid is high for exactly one cycle, in the cycle in which csN has just risen. resultA and resultB hold their values from that point until the next frame completes.
- R9: busy is high from the accepted start until CS_HIGH_MIN cycles after csN rises. A start request while busy is ignored. With start held high, csN stays high for CS_HIGH_MIN+1 cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a frame; taken only when not busy |
| singleLine | input | 1 | Single-line mode for the frame being started |
| captureRise | input | 1 | 1: capture on sclk rising edges, 0: capture on falling edges |
| sdataA | input | 1 | Serial data line of channel A |
| sdataB | input | 1 | Serial data line of channel B |
| csN | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock to the converter, idle high |
| busy | output | 1 | A frame or the chip-select high time is in progress |
| valid | output | 1 | One-cycle pulse: new results are present |
| resultA | output | 12 | Channel A result |
| resultB | output | 12 | Channel B result (from line A in single-line mode) |

## Verification
At the end of a frame, the completion of the previous frame and the acceptance of a new start can fall close together. A start that is held high meets the valid pulse, the chip-select high interval and the return to idle in consecutive cycles. The bench keeps start asserted across a frame boundary and requires a high time of exactly CS_HIGH_MIN+1 cycles. It also checks that the previous results are still present in the middle of the following frame. A second collision is a start pulse in the middle of a frame. That frame must still end with the correct edge count, and no further frame may follow it.

// File: rtl/dual_adc_reader_pkg.sv
package dual_adc_reader_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic clear;    // begin a new frame: zero the sample count
    logic sample;   // take one bit from the data lines this cycle
    logic publish;  // copy the assembled words to the result outputs
    logic single;   // frame runs in single-line mode
  } dpStrobe_t;

endpackage

// File: rtl/dual_adc_reader_ctrl.sv
module dual_adc_reader_ctrl
  import dual_adc_reader_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int CS_HIGH_MIN = 4,
  parameter int DATA_W      = 12,
  parameter int LATENCY     = 19
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      singleLine,
  input  logic      captureRise,
  output logic      csN,
  output logic      sclk,
  output logic      busy,
  output logic      valid,
  output dpStrobe_t strobe
);

  localparam int HALF      = SCLK_DIV / 2;
  localparam int HALF_W    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGES_ONE = LATENCY + DATA_W;
  localparam int EDGES_TWO = LATENCY + 2 * DATA_W;
  localparam int CNT_W     = $clog2(EDGES_TWO + 2);
  localparam int GAP_W     = (CS_HIGH_MIN > 1) ? $clog2(CS_HIGH_MIN) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} state_t;

  state_t            state;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  fallCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              singleQ;
  logic              riseQ;

  logic              tick;
  logic [CNT_W-1:0]  lastEdge;
  logic [CNT_W-1:0]  winHigh;
  logic [CNT_W-1:0]  fallIdx;
  logic              fallWin;
  logic              riseWin;

  assign tick     = (halfCnt == HALF_W'(HALF - 1));
  assign lastEdge = singleQ ? CNT_W'(EDGES_TWO) : CNT_W'(EDGES_ONE);
  assign winHigh  = lastEdge;
  assign fallIdx  = fallCnt + 1'b1;
  // falling capture: edges LATENCY+1 .. lastEdge
  assign fallWin  = (fallIdx >= CNT_W'(LATENCY + 1)) && (fallIdx <= winHigh);
  // rising capture: rise following falls LATENCY .. lastEdge-1
  assign riseWin  = (fallCnt >= CNT_W'(LATENCY)) && (fallCnt < winHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      csN     <= 1'b1;
      sclk    <= 1'b1;
      halfCnt <= '0;
      fallCnt <= '0;
      gapCnt  <= '0;
      singleQ <= 1'b0;
      riseQ   <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_FRAME;
            csN     <= 1'b0;
            halfCnt <= '0;
            fallCnt <= '0;
            singleQ <= singleLine;
            riseQ   <= captureRise;
          end
        end
        S_FRAME: begin
          if (tick) begin
            halfCnt <= '0;
            if (sclk) begin
              sclk    <= 1'b0;
              fallCnt <= fallIdx;
            end else begin
              sclk <= 1'b1;
              if (fallCnt == lastEdge) begin
                csN    <= 1'b1;
                valid  <= 1'b1;
                state  <= S_GAP;
                gapCnt <= '0;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_W'(CS_HIGH_MIN - 1)) state <= S_IDLE;
          else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    strobe.clear   = (state == S_IDLE) && start;
    strobe.sample  = (state == S_FRAME) && tick &&
                     (sclk ? (!riseQ && fallWin) : (riseQ && riseWin));
    strobe.publish = (state == S_FRAME) && tick && !sclk && (fallCnt == lastEdge);
    strobe.single  = singleQ;
  end

  // R2
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> sclk);

  // R3
  sclk_fall_inside_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (!csN && $past(!csN)));

  // R8
  valid_with_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> $rose(csN));

  // R8
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R9
  frame_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(!busy));

endmodule

// File: rtl/dual_adc_reader_dp.sv
module dual_adc_reader_dp
  import dual_adc_reader_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdataA,
  input  logic              sdataB,
  output logic [DATA_W-1:0] resultA,
  output logic [DATA_W-1:0] resultB
);

  localparam int LANES  = 2;
  localparam int SCNT_W = $clog2(2 * DATA_W + 1);

  logic [DATA_W-1:0] lane [LANES];
  logic              laneIn [LANES];
  logic [SCNT_W-1:0] sampCnt;

  // lane 1 collects channel A, lane 0 channel B; in single-line mode
  // lane 0 takes line A and overflows into lane 1
  assign laneIn[1] = strobe.single ? lane[0][DATA_W-1] : sdataA;
  assign laneIn[0] = strobe.single ? sdataA : sdataB;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) lane[g] <= '0;
      else if (strobe.sample) lane[g] <= {lane[g][DATA_W-2:0], laneIn[g]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sampCnt <= '0;
    else if (strobe.clear) sampCnt <= '0;
    else if (strobe.sample) sampCnt <= sampCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultA <= '0;
      resultB <= '0;
    end else if (strobe.publish) begin
      resultA <= lane[1];
      resultB <= lane[0];
    end
  end

  // R5 R6 R7: a frame is published only after a full set of bits
  bit_count_at_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |-> (sampCnt == (strobe.single ? SCNT_W'(2 * DATA_W) : SCNT_W'(DATA_W))));

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dual_adc_reader_pkg::*;
#(
  parameter int SCLK_DIV    = 4,
  parameter int CS_HIGH_MIN = 4,
  parameter int DATA_W      = 12,
  parameter int LATENCY     = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              singleLine,
  input  logic              captureRise,
  input  logic              sdataA,
  input  logic              sdataB,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] resultA,
  output logic [DATA_W-1:0] resultB
);

  dpStrobe_t strobe;

  dual_adc_reader_ctrl #(
    .SCLK_DIV(SCLK_DIV), .CS_HIGH_MIN(CS_HIGH_MIN),
    .DATA_W(DATA_W), .LATENCY(LATENCY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .singleLine(singleLine),
    .captureRise(captureRise), .csN(csN), .sclk(sclk), .busy(busy),
    .valid(valid), .strobe(strobe)
  );

  dual_adc_reader_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdataA(sdataA),
    .sdataB(sdataB), .resultA(resultA), .resultB(resultB)
  );

endmodule

// File: tb/dual_adc_reader_tb.sv
module dual_adc_reader_tb;

  localparam int SCLK_DIV    = 4;
  localparam int HALF        = SCLK_DIV / 2;
  localparam int CS_HIGH_MIN = 3;
  localparam int W           = 12;
  localparam int NVEC        = 6;
  // {singleLine, captureRise, valueA, valueB}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 12'hA5C, 12'h3F1},
    {1'b0, 1'b1, 12'hFFF, 12'h000},
    {1'b0, 1'b1, 12'h800, 12'h001},
    {1'b1, 1'b0, 12'h123, 12'hABC},
    {1'b1, 1'b1, 12'hF0F, 12'h0F0},
    {1'b0, 1'b0, 12'h001, 12'h800}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic singleLine = 1'b0;
  logic captureRise = 1'b0;
  logic sdataA = 1'b1;
  logic sdataB = 1'b1;
  logic csN, sclk, busy, valid;
  logic [W-1:0] resultA, resultB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int fcnt = 0;
  logic [2*W-1:0] seqA = '0;
  logic [2*W-1:0] seqB = '0;

  always #10 clk = ~clk;

  dual_adc_reader #(.SCLK_DIV(SCLK_DIV), .CS_HIGH_MIN(CS_HIGH_MIN)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .singleLine(singleLine),
    .captureRise(captureRise), .sdataA(sdataA), .sdataB(sdataB),
    .csN(csN), .sclk(sclk), .busy(busy), .valid(valid),
    .resultA(resultA), .resultB(resultB)
  );

  // Converter model: bit k of the stream appears after falling edge 19+k
  always @(negedge sclk or negedge csN) begin
    if (!csN) begin
      if (sclk) begin
        fcnt = 0;
        sdataA = 1'b1;
        sdataB = 1'b1;
      end else begin
        fcnt = fcnt + 1;
        if (fcnt >= 19 && fcnt <= 19 + 2 * W - 1) begin
          sdataA = seqA[2*W-1-(fcnt-19)];
          sdataB = seqB[2*W-1-(fcnt-19)];
        end else begin
          sdataA = 1'b1;
          sdataB = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic waitValid();
    int n = 0;
    while (!valid && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic runFrame(input bit sgl, input bit rise,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit poke);
    int n;
    string req;
    seqA = {a, b};
    seqB = {b, a};
    req = sgl ? "R7" : (rise ? "R6" : "R5");
    @(negedge clk);
    singleLine = sgl; captureRise = rise; start = 1'b1;
    @(negedge clk);
    start = 1'b0; singleLine = ~sgl; captureRise = ~rise;
    chk(csN == 1'b0 && sclk == 1'b1, "R3", "cs low with sclk high", {csN, sclk}, 2'b01);
    n = 0; while (sclk && n < 100) begin @(negedge clk); n++; end
    chk(n == HALF, "R3", "cs fall to first sclk fall", n, HALF);
    n = 0; while (!sclk && n < 100) begin @(negedge clk); n++; end
    chk(n == HALF, "R2", "sclk low time", n, HALF);
    n = 0; while (sclk && n < 100) begin @(negedge clk); n++; end
    chk(n == HALF, "R2", "sclk high time", n, HALF);
    if (poke) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waitValid();
    chk(valid == 1'b1, "R8", "valid seen", valid, 1);
    chk(csN == 1'b1, "R8", "cs high with valid", csN, 1);
    chk(fcnt == (sgl ? 43 : 31), "R4", "falling edges in frame", fcnt, sgl ? 43 : 31);
    chk(resultA == a, req, "resultA", resultA, a);
    chk(resultB == b, req, "resultB", resultB, b);
    @(negedge clk);
    chk(valid == 1'b0, "R8", "valid one cycle", valid, 0);
    n = 0; while (busy && n < 100) begin @(negedge clk); n++; end
    chk(n == CS_HIGH_MIN - 1, "R9", "busy after cs rise", n + 1, CS_HIGH_MIN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(csN == 1'b1 && sclk == 1'b1, "R1", "cs/sclk in reset", {csN, sclk}, 2'b11);
    chk(busy == 1'b0 && valid == 1'b0, "R1", "busy/valid in reset", {busy, valid}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b1 && !busy && !valid, "R1", "idle after reset",
        {csN, sclk, busy, valid}, 4'b1100);

    for (int i = 0; i < NVEC; i++) begin
      runFrame(VEC[i][25], VEC[i][24], VEC[i][23:12], VEC[i][11:0], 1'b0);
    end

    // R9: start pulse in mid-frame is ignored, no extra frame follows
    runFrame(1'b0, 1'b0, 12'h6B2, 12'h94D, 1'b1);
    repeat (6) @(negedge clk);
    chk(csN == 1'b1 && !busy, "R9", "no frame from mid-frame start", {csN, busy}, 2'b10);

    // R9/R8: start held across a frame boundary
    seqA = {12'h5A5, 12'h1E1};
    seqB = {12'h1E1, 12'h5A5};
    singleLine = 1'b0; captureRise = 1'b1;
    @(negedge clk); start = 1'b1;
    waitValid();
    chk(resultA == 12'h5A5, "R6", "held-start frame A", resultA, 12'h5A5);
    n = 0; while (csN && n < 100) begin @(negedge clk); n++; end
    chk(n == CS_HIGH_MIN + 1, "R9", "cs high time with start held", n, CS_HIGH_MIN + 1);
    start = 1'b0;
    seqA = {12'h2C3, 12'hD4B};
    seqB = {12'hD4B, 12'h2C3};
    repeat (40) @(negedge clk);
    chk(resultA == 12'h5A5 && resultB == 12'h1E1, "R8", "results held mid-frame",
        {resultA, resultB}, {12'h5A5, 12'h1E1});
    waitValid();
    chk(resultA == 12'h2C3 && resultB == 12'hD4B, "R6", "second frame results",
        {resultA, resultB}, {12'h2C3, 12'hD4B});

    // R7: line B differs from line A stream, must not affect single-line results
    seqA = {12'h3C5, 12'hA96};
    seqB = {12'hFFF, 12'hFFF};
    @(negedge clk); while (busy) @(negedge clk);
    singleLine = 1'b1; captureRise = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitValid();
    chk(resultA == 12'h3C5 && resultB == 12'hA96, "R7", "line B ignored",
        {resultA, resultB}, {12'h3C5, 12'hA96});

    repeat (10) @(negedge clk);
    summary();
  end

endmodule